// File: doc/BRIEF.md
# Framed Manchester Line Transmitter

This block turns parallel 16-bit samples into a self-clocking serial line signal. Every sample travels in its own frame. A frame opens with a long run of zero bits that a receiver can lock onto. A single one-valued marker bit follows, and then the sample bits, most significant first. Each bit period is split into two half-bit slots. The line carries the bit in the first slot and its complement in the second, so every bit has a transition in its middle and the signal averages a 50% duty cycle.

The system clock is free-running. A half-bit enable pulse, `tick_i`, marks each half-bit slot, so with a 1 MHz bit rate the enable pulses at 2 MHz.

The bit value and the half-bit phase are captured together in one register stage on the same edge. Their exclusive-OR is then captured again before it reaches the pin. The output is therefore a plain flip-flop and cannot glitch from skew between the two.

New samples are taken only at the frame boundary, through a valid/ready handshake. If no sample arrives at a boundary, the next frame either repeats the previous sample or sends zeros, as selected by a parameter.

Top module: `manch_frame_tx`

## Requirements
- R1: A frame is 48 bit periods long. Bit positions 0 to 30 are zero, bit 31 (the marker) is one, and positions 32 to 47 carry the sample. Frames follow each other with no gap.
- R2: The sample bits are sent most significant bit first: position 32 carries bit 15 and position 47 carries bit 0.
- R3: Every bit period is two half-bit slots. The first slot drives the bit value on the line and the second drives its complement (line = bit XOR phase, where phase is 0 then 1).
- R4: Each `tick_i` pulse sampled at a rising clock edge starts one half-bit slot. The line shows that slot's value from the following rising edge onward.
- R5: `smp_ready_o` is high only while `tick_i` is high in the second half of bit position 47. When `smp_valid_i` is also high in that cycle, `smp_data_i` is taken and sent in the next frame.
- R6: If no sample is taken at a boundary, the next frame sends the previous frame's sample when HOLD_LAST is 1, and all-zero data when HOLD_LAST is 0.
- R7: After synchronous reset, `line_o` and `smp_ready_o` are low. The first frame starts at bit position 0, first half, and its data field is all zero.
- R8: At least 18 consecutive zero bit periods precede every marker bit.
- R9: While `tick_i` stays low, the line level and the frame position do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Half-bit slot enable |
| smp_valid_i | input | 1 | Sample offered |
| smp_data_i | input | 16 | Sample value |
| smp_ready_o | output | 1 | Sample taken this cycle (with valid) |
| line_o | output | 1 | Manchester-coded serial line |

## Verification
A wrong frame position or a wrong shift-register bit shows on the line within one half-bit slot, one clock after the tick that starts the slot. The bench compares every slot of 24 consecutive frames against an arithmetic model. A fault in the half-bit phase breaks the mid-bit inversion in the very next slot. A fault at the frame boundary shows up in one of two ways: as a ready pulse outside the final slot, or as a wrong data field one frame later. Both parameter variants run side by side on the same stimulus, which separates the repeat and zero-fill behaviours.

// File: rtl/manch_tx_pkg.sv
package manch_tx_pkg;

    // Zero bit periods a receiver needs ahead of a marker to regain lock
    localparam int unsigned RESYNC_MIN = 18;

    typedef enum logic [1:0] {
        SEG_PRE,
        SEG_START,
        SEG_DATA
    } seg_e;

    // Bit value and half-bit phase travel together so they are retimed as a pair
    typedef struct packed {
        logic dat;
        logic phs;
    } pair_t;

    function automatic int unsigned frame_len(input int unsigned dw, input int unsigned pre);
        return pre + 1 + dw;
    endfunction

    function automatic seg_e seg_of(input int unsigned pos, input int unsigned pre);
        if (pos < pre)
            return SEG_PRE;
        else if (pos == pre)
            return SEG_START;
        else
            return SEG_DATA;
    endfunction

endpackage

// File: rtl/mtx_frame_seq.sv
module mtx_frame_seq
    import manch_tx_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned PRE_ZEROS = 31,
    parameter bit          HOLD_LAST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    output logic              smp_ready_o,
    output pair_t             pair_o
);
    localparam int unsigned FRAME = frame_len(DATA_W, PRE_ZEROS);
    localparam int unsigned POS_W = $clog2(FRAME);
    localparam int unsigned LAST  = FRAME - 1;

    logic [POS_W-1:0]  pos_q;
    logic              half_q;
    logic [DATA_W-1:0] shr_q;
    logic [DATA_W-1:0] refill;
    logic              at_end;
    logic              take;
    logic              cur_bit;
    seg_e              seg;

    assign seg         = seg_of(32'(pos_q), PRE_ZEROS);
    assign at_end      = half_q && (pos_q == POS_W'(LAST));
    assign smp_ready_o = tick_i && at_end;
    assign take        = smp_ready_o && smp_valid_i;

    always_comb begin
        case (seg)
            SEG_PRE:   cur_bit = 1'b0;
            SEG_START: cur_bit = 1'b1;
            default:   cur_bit = shr_q[DATA_W-1];
        endcase
    end

    assign pair_o = '{dat: cur_bit, phs: half_q};

    // Refill source when no new sample arrives at the boundary
    generate
        if (HOLD_LAST) begin : g_hold
            logic [DATA_W-1:0] last_q;
            always_ff @(posedge clk) begin
                if (rst)
                    last_q <= '0;
                else if (take)
                    last_q <= smp_data_i;
            end
            assign refill = last_q;
        end else begin : g_zero
            assign refill = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            half_q <= 1'b0;
            shr_q  <= '0;
        end else if (tick_i) begin
            half_q <= ~half_q;
            if (half_q) begin
                if (at_end) begin
                    pos_q <= '0;
                    shr_q <= take ? smp_data_i : refill;
                end else begin
                    pos_q <= pos_q + POS_W'(1);
                    if (seg == SEG_DATA)
                        shr_q <= shr_q << 1;
                end
            end
        end
    end

    // Run length of zero bit periods, kept for the resync check
    logic [7:0] zrun_q;
    always_ff @(posedge clk) begin
        if (rst)
            zrun_q <= '0;
        else if (tick_i && half_q)
            zrun_q <= cur_bit ? 8'd0 : ((zrun_q == 8'hFF) ? zrun_q : zrun_q + 8'd1);
    end

    a_r8_zero_run: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !half_q && seg == SEG_START) |-> (zrun_q >= 8'(RESYNC_MIN)));

    a_r1_pos_step: assert property (@(posedge clk) disable iff (rst)
        (tick_i && half_q && !at_end) |=> (pos_q == $past(pos_q) + POS_W'(1)));

    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        smp_ready_o |=> (pos_q == '0 && !half_q));

    a_r9_stall: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ($stable(pos_q) && $stable(half_q) && $stable(shr_q)));

endmodule

// File: rtl/mtx_retime.sv
module mtx_retime
    import manch_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  pair_t pair_i,
    output logic  line_o
);
    pair_t pair_q;
    logic  line_q;
    logic  seen_q;

    // Bit and phase are captured on one edge, then the XOR is registered
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
            line_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            if (tick_i) begin
                pair_q <= pair_i;
                seen_q <= 1'b1;
            end
            line_q <= pair_q.dat ^ pair_q.phs;
        end
    end

    assign line_o = line_q;

    a_r3_phase_alt: assert property (@(posedge clk) disable iff (rst)
        (tick_i && seen_q) |-> (pair_i.phs != pair_q.phs));

    a_r3_bit_held: assert property (@(posedge clk) disable iff (rst)
        (tick_i && seen_q && pair_i.phs) |-> (pair_i.dat == pair_q.dat));

    a_r4_line_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !$past(tick_i)) |=> $stable(line_q));

endmodule

// File: rtl/manch_frame_tx.sv
module manch_frame_tx
    import manch_tx_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned PRE_ZEROS = 31,
    parameter bit          HOLD_LAST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    output logic              smp_ready_o,
    output logic              line_o
);
    pair_t pair;

    mtx_frame_seq #(
        .DATA_W   (DATA_W),
        .PRE_ZEROS(PRE_ZEROS),
        .HOLD_LAST(HOLD_LAST)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .smp_valid_i(smp_valid_i),
        .smp_data_i (smp_data_i),
        .smp_ready_o(smp_ready_o),
        .pair_o     (pair)
    );

    mtx_retime rt_i (
        .clk   (clk),
        .rst   (rst),
        .tick_i(tick_i),
        .pair_i(pair),
        .line_o(line_o)
    );

endmodule

// File: tb/manch_frame_tx_tb_top.sv
module manch_frame_tx_tb_top;
    localparam int DW   = 16;
    localparam int PRE  = 31;
    localparam int SPF  = 2 * (PRE + 1 + DW);  // half-bit slots per frame
    localparam int NFR  = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic vld = 1'b0;
    logic [DW-1:0] dat = '0;
    logic rdy_h, rdy_z, line_h, line_z;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    manch_frame_tx #(.DATA_W(DW), .PRE_ZEROS(PRE), .HOLD_LAST(1'b1)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .smp_valid_i(vld), .smp_data_i(dat),
        .smp_ready_o(rdy_h), .line_o(line_h));

    manch_frame_tx #(.DATA_W(DW), .PRE_ZEROS(PRE), .HOLD_LAST(1'b0)) dut_z_i (
        .clk(clk), .rst(rst), .tick_i(tick), .smp_valid_i(vld), .smp_data_i(dat),
        .smp_ready_o(rdy_z), .line_o(line_z));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit plan_valid(input int f);
        return !(f == 1 || f == 5 || f == 12 || f == 13 || f == 20);
    endfunction

    function automatic logic [DW-1:0] plan_data(input int f);
        case (f)
            0: return 16'hA5C3;
            2: return 16'hFFFF;
            3: return 16'h8001;
            4: return 16'h0000;
            6: return 16'h1234;
            7: return 16'h7FFE;
            default: return 16'(1) << (f - 8);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] cur_h, cur_z, nxt_h, nxt_z;
        bit repeat_frame;
        cur_h = '0;
        cur_z = '0;
        nxt_h = '0;
        nxt_z = '0;
        repeat_frame = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: idle state after reset
        chk("R7 line after reset", int'(line_h), 0);
        chk("R7 line after reset zero-fill", int'(line_z), 0);
        chk("R7 ready after reset", int'(rdy_h), 0);
        chk("R7 ready after reset zero-fill", int'(rdy_z), 0);

        for (int k = 0; k < NFR * SPF; k++) begin
            int f, h, b, p, eb_h, eb_z;
            string tag;
            f = k / SPF;
            h = k % SPF;
            b = h / 2;
            p = h % 2;
            if (h == 0) begin
                vld = plan_valid(f);
                dat = plan_data(f);
            end
            tick = 1'b1;
            #1;
            // R5: ready only in the final half-bit slot of a frame
            chk("R5 ready during tick", int'(rdy_h), (h == SPF - 1) ? 1 : 0);
            chk("R5 ready during tick zero-fill", int'(rdy_z), (h == SPF - 1) ? 1 : 0);
            @(negedge clk);
            tick = 1'b0;
            if (h == SPF - 1) begin
                nxt_h = vld ? dat : cur_h;
                nxt_z = vld ? dat : '0;
            end
            @(negedge clk);
            if (b < PRE) begin
                eb_h = 0; eb_z = 0; tag = "R1 R8 preamble";
            end else if (b == PRE) begin
                eb_h = 1; eb_z = 1; tag = "R1 marker";
            end else begin
                eb_h = int'(cur_h[DW - 1 - (b - PRE - 1)]);
                eb_z = int'(cur_z[DW - 1 - (b - PRE - 1)]);
                tag = (f == 0) ? "R7 first frame data" :
                      (repeat_frame ? "R6 refill data" : "R2 data msb first");
            end
            // R3 R4: slot value appears one clock after its tick
            chk({tag, " R3 R4 hold"}, int'(line_h), eb_h ^ p);
            chk({tag, " R3 R4 zero-fill"}, int'(line_z), eb_z ^ p);
            chk("R5 ready without tick", int'(rdy_h), 0);
            if (k == 150 || k == 151) begin
                // R9: no tick, no change
                for (int s = 0; s < 10; s++) begin
                    @(negedge clk);
                    chk("R9 stall hold", int'(line_h), eb_h ^ p);
                    chk("R9 stall zero-fill", int'(line_z), eb_z ^ p);
                end
            end
            if (h == SPF - 1) begin
                repeat_frame = !vld;
                cur_h = nxt_h;
                cur_z = nxt_z;
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule